// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block sequences instruction addresses for a small microcontroller core. It keeps a 13-bit program counter and an eight-entry hardware return stack. Each clock cycle it applies one control request chosen from reset, interrupt entry, call, jump, the three return operations, or a plain increment. The core's decode logic raises these request strobes. The counter can address 8K words, but only the low 1K words of program memory exist. The fetch address sent to memory is therefore the low ten bits of the counter, so any higher address wraps into the implemented region, while the full 13-bit value stays inside the block.

The reset vector is address 0000h and the interrupt vector is address 0004h. Calls and interrupts share one return stack. The stack is circular and has no overflow or underflow indication. A return from interrupt is reported to the surrounding logic as a one-cycle pulse. Fetch, decode, the returned literal and interrupt enabling are handled elsewhere.

Top module: `pc_sequencer`

## Requirements
- R1: `fetch_addr` always equals bits 9:0 of `pc`, and `pc` keeps all 13 bits (a jump to 1ABCh leaves `pc`=1ABCh and `fetch_addr`=2BCh).
- R2: While `rst_n` is low at a rising clock edge, `pc` becomes 0000h, `retfie_pulse` becomes 0, the stack pointer returns to empty, and every stack entry is cleared. A return issued right after reset therefore yields 0000h.
- R3: Interrupt entry (`irq_take`) pushes the current `pc` value, which is the instruction that would run next, and loads `pc` with 0004h.
- R4: An increment (`step`) loads `pc`+1 modulo 8192, so 1FFFh is followed by 0000h.
- R5: A jump (`jump_en`) loads `pc` with `target`.
- R6: A call (`call_en`) pushes `pc`+1 (modulo 8192) and loads `pc` with `target`.
- R7: A return (`ret_en`) or a return with literal (`retlw_en`) pops the most recently pushed address into `pc`.
- R8: A return from interrupt (`retfie_en`) pops into `pc` like a return. `retfie_pulse` is 1 in the single cycle that follows it and 0 at all other times.
- R9: The stack holds eight entries and is circular. A ninth push without any pop overwrites the oldest entry, and a pop from the empty stack reads the entry at the wrapped pointer. After nine pushes of A1..A9, nine pops return A9, A8, ..., A2, A9.
- R10: When several requests arrive together, only the highest-priority one takes effect. The priority order is reset, interrupt, call, jump, return, return from interrupt, return with literal, increment. Lower-priority requests neither push nor pop.
- R11: With no request asserted, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_take | input | 1 | Interrupt entry request |
| step | input | 1 | Sequential increment request |
| jump_en | input | 1 | Jump request |
| call_en | input | 1 | Call request |
| ret_en | input | 1 | Return request |
| retfie_en | input | 1 | Return-from-interrupt request |
| retlw_en | input | 1 | Return-with-literal request |
| target | input | 13 | Destination address for jump and call |
| pc | output | 13 | Full program counter |
| fetch_addr | output | 10 | Wrapped program memory fetch address |
| retfie_pulse | output | 1 | One-cycle report of a return from interrupt |

## Verification
A wrong stack pointer or a corrupted stack entry cannot be seen until the next pop. At that point `pc` takes a wrong value one cycle after the return, which can be many cycles after the fault happened. For this reason the bench mixes long call and interrupt chains with returns, and it also wraps the stack past eight levels. A wrong priority decision or increment shows up at `pc` on the very next cycle. A wrong fetch slice shows up at once wherever `pc` has bits set above bit 9.

// File: rtl/pcseq_pkg.sv
// pcseq_pkg: shared operation encoding and widths for the program
// counter sequencer. Assumes a single clock domain.
package pcseq_pkg;

    // One decoded control operation per cycle, after priority resolution.
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_STEP   = 3'd1,
        OP_JUMP   = 3'd2,
        OP_CALL   = 3'd3,
        OP_RET    = 3'd4,
        OP_RETFIE = 3'd5,
        OP_RETLW  = 3'd6,
        OP_IRQ    = 3'd7
    } seq_op_e;

    // Request bundle as seen by the arbiter.
    typedef struct packed {
        logic irq;
        logic call;
        logic jump;
        logic ret;
        logic retfie;
        logic retlw;
        logic step;
    } seq_req_t;

endpackage

// File: rtl/pcseq_arbiter.sv
// pcseq_arbiter: turns the raw request strobes into one operation.
// Fixed priority: interrupt, call, jump, return, return from interrupt,
// return with literal, increment. Reset is handled in the registers.
// Assumes requests are stable around the clock edge.
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  seq_req_t req,
    output seq_op_e  op
);

    // Priority chain: the first asserted request in order wins.
    always_comb begin
        if (req.irq)         op = OP_IRQ;
        else if (req.call)   op = OP_CALL;
        else if (req.jump)   op = OP_JUMP;
        else if (req.ret)    op = OP_RET;
        else if (req.retfie) op = OP_RETFIE;
        else if (req.retlw)  op = OP_RETLW;
        else if (req.step)   op = OP_STEP;
        else                 op = OP_HOLD;
    end

endmodule

// File: rtl/pcseq_stack.sv
// pcseq_stack: circular return-address stack. A push writes at the
// pointer and advances it. A pop reads the entry below the pointer and
// retreats. Both wrap at DEPTH with no overflow indication. A push and a
// pop never arrive together (the arbiter grants one operation). Synchronous
// active-low reset clears the pointer and every entry.
module pcseq_stack #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic [WIDTH-1:0] entry [DEPTH];

    // Wrapped neighbours of the pointer, valid for any DEPTH.
    always_comb begin
        ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
        ptr_dec = (ptr == '0) ? LAST : ptr - 1'b1;
    end

    // Pointer update: advance on push, retreat on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (push) ptr <= ptr_inc;
        else if (pop)  ptr <= ptr_dec;
    end

    // One register per stack level, written only when addressed by a push.
    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= '0;
            else if (push && (ptr == PTR_W'(g)))
                entry[g] <= push_data;
        end
    end

    // Pop data: the most recently written level.
    assign top_data = entry[ptr_dec];

endmodule

// File: rtl/pcseq_pc_reg.sv
// pcseq_pc_reg: program counter register and the return-from-interrupt
// report. Computes the next counter value, the stack push value and the
// stack controls from the granted operation. Synchronous active-low reset
// loads RESET_VEC.
module pcseq_pc_reg
    import pcseq_pkg::*;
#(
    parameter int              PC_W      = 13,
    parameter logic [PC_W-1:0] RESET_VEC = '0,
    parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_op_e         op,
    input  logic [PC_W-1:0] target,
    input  logic [PC_W-1:0] pop_data,
    output logic [PC_W-1:0] pc,
    output logic            push,
    output logic            pop,
    output logic [PC_W-1:0] push_data,
    output logic            retfie_pulse
);

    logic [PC_W-1:0] pc_plus1;
    logic [PC_W-1:0] pc_next;

    // Sequential successor, wrapping at the full counter width.
    assign pc_plus1 = pc + 1'b1;

    // Next counter value per operation.
    always_comb begin
        case (op)
            OP_STEP:                    pc_next = pc_plus1;
            OP_JUMP, OP_CALL:           pc_next = target;
            OP_RET, OP_RETFIE, OP_RETLW: pc_next = pop_data;
            OP_IRQ:                     pc_next = IRQ_VEC;
            default:                    pc_next = pc;
        endcase
    end

    // Stack controls: calls save the successor, interrupts save the current pc.
    always_comb begin
        push      = (op == OP_CALL) || (op == OP_IRQ);
        pop       = (op == OP_RET) || (op == OP_RETFIE) || (op == OP_RETLW);
        push_data = (op == OP_CALL) ? pc_plus1 : pc;
    end

    // Counter and report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc           <= RESET_VEC;
            retfie_pulse <= 1'b0;
        end else begin
            pc           <= pc_next;
            retfie_pulse <= (op == OP_RETFIE);
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
// pc_sequencer: top of the program-sequencing unit. Arbitrates the request
// strobes, updates the program counter and the shared return stack, and
// presents the fetch address wrapped into the implemented program memory.
// Assumes one clock and a synchronous active-low reset.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int FETCH_W     = 10,
    parameter int STACK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_take,
    input  logic               step,
    input  logic               jump_en,
    input  logic               call_en,
    input  logic               ret_en,
    input  logic               retfie_en,
    input  logic               retlw_en,
    input  logic [PC_W-1:0]    target,
    output logic [PC_W-1:0]    pc,
    output logic [FETCH_W-1:0] fetch_addr,
    output logic               retfie_pulse
);

    seq_req_t        req;
    seq_op_e         op;
    logic            stk_push;
    logic            stk_pop;
    logic [PC_W-1:0] stk_wdata;
    logic [PC_W-1:0] stk_top;

    // Gather the strobes into the request bundle.
    always_comb begin
        req.irq    = irq_take;
        req.call   = call_en;
        req.jump   = jump_en;
        req.ret    = ret_en;
        req.retfie = retfie_en;
        req.retlw  = retlw_en;
        req.step   = step;
    end

    pcseq_arbiter u_arb (
        .req (req),
        .op  (op)
    );

    pcseq_pc_reg #(
        .PC_W      (PC_W),
        .RESET_VEC ('0),
        .IRQ_VEC   (PC_W'(4))
    ) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .target       (target),
        .pop_data     (stk_top),
        .pc           (pc),
        .push         (stk_push),
        .pop          (stk_pop),
        .push_data    (stk_wdata),
        .retfie_pulse (retfie_pulse)
    );

    pcseq_stack #(
        .WIDTH (PC_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_wdata),
        .top_data  (stk_top)
    );

    // Wrap into the implemented region by dropping the upper counter bits.
    assign fetch_addr = pc[FETCH_W-1:0];

endmodule

// File: rtl/pcseq_checker.sv
// pcseq_checker: temporal properties of pc_sequencer, observed at its ports
// and attached with bind.
module pcseq_checker #(
    parameter int PC_W    = 13,
    parameter int FETCH_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_take,
    input logic               step,
    input logic               jump_en,
    input logic               call_en,
    input logic               ret_en,
    input logic               retfie_en,
    input logic               retlw_en,
    input logic [PC_W-1:0]    target,
    input logic [PC_W-1:0]    pc,
    input logic [FETCH_W-1:0] fetch_addr,
    input logic               retfie_pulse
);

    logic any_pop;
    assign any_pop = ret_en || retfie_en || retlw_en;

    p_reset_vec_r2: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !retfie_pulse));

    p_irq_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> pc == PC_W'(4));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !irq_take && !call_en && !jump_en && !any_pop)
        |=> pc == PC_W'($past(pc) + 1'b1));

    p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_en && !irq_take && !call_en) |=> pc == $past(target));

    p_call_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_en && !irq_take) |=> pc == $past(target));

    p_retfie_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retfie_pulse |-> $past(retfie_en && !irq_take && !call_en
                               && !jump_en && !ret_en));

    p_retfie_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retfie_en && !irq_take && !call_en && !jump_en && !ret_en)
        |=> retfie_pulse);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !irq_take && !call_en && !jump_en && !any_pop)
        |=> $stable(pc));

endmodule

bind pc_sequencer pcseq_checker #(
    .PC_W    (PC_W),
    .FETCH_W (FETCH_W)
) i_pcseq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_take     (irq_take),
    .step         (step),
    .jump_en      (jump_en),
    .call_en      (call_en),
    .ret_en       (ret_en),
    .retfie_en    (retfie_en),
    .retlw_en     (retlw_en),
    .target       (target),
    .pc           (pc),
    .fetch_addr   (fetch_addr),
    .retfie_pulse (retfie_pulse)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_take, step, jump_en, call_en, ret_en, retfie_en, retlw_en;
    logic [12:0] target;
    logic [12:0] pc;
    logic [9:0]  fetch_addr;
    logic        retfie_pulse;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    int          m_ptr;
    logic        m_rf;

    always #2.5 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .step(step),
        .jump_en(jump_en), .call_en(call_en), .ret_en(ret_en),
        .retfie_en(retfie_en), .retlw_en(retlw_en), .target(target),
        .pc(pc), .fetch_addr(fetch_addr), .retfie_pulse(retfie_pulse)
    );

    // Operation winner per R10: 7 irq, 6 call, 5 jump, 4 ret, 3 retfie, 2 retlw, 1 step, 0 hold.
    function automatic int winner(logic i, logic c, logic j, logic r,
                                  logic rf, logic rl, logic s);
        if (i) return 7;
        if (c) return 6;
        if (j) return 5;
        if (r) return 4;
        if (rf) return 3;
        if (rl) return 2;
        if (s) return 1;
        return 0;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            7: return "R3";
            6: return "R6";
            5: return "R5";
            4, 2: return "R7";
            3: return "R8";
            1: return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0;
        m_ptr = 0;
        m_rf = 1'b0;
        for (int k = 0; k < 8; k++) m_stk[k] = '0;
    endtask

    task automatic model_step(int op, logic [12:0] tgt);
        m_rf = (op == 3);
        case (op)
            7: begin m_stk[m_ptr] = m_pc; m_ptr = (m_ptr + 1) % 8; m_pc = 13'h0004; end
            6: begin m_stk[m_ptr] = m_pc + 13'd1; m_ptr = (m_ptr + 1) % 8; m_pc = tgt; end
            5: m_pc = tgt;
            4, 3, 2: begin m_ptr = (m_ptr + 7) % 8; m_pc = m_stk[m_ptr]; end
            1: m_pc = m_pc + 13'd1;
            default: ;
        endcase
    endtask

    task automatic compare(string req);
        check(req, pc, m_pc);
        check("R1", fetch_addr, m_pc[9:0]);
        check(m_rf ? "R8" : req, retfie_pulse, m_rf);
    endtask

    // Drive one cycle of requests (called just after a falling edge).
    task automatic drive(logic i, logic c, logic j, logic r, logic rf,
                         logic rl, logic s, logic [12:0] tgt, string req);
        int op;
        int n;
        irq_take = i; call_en = c; jump_en = j; ret_en = r;
        retfie_en = rf; retlw_en = rl; step = s; target = tgt;
        op = winner(i, c, j, r, rf, rl, s);
        n = i + c + j + r + rf + rl + s;
        model_step(op, tgt);
        @(posedge clk);
        @(negedge clk);
        compare(req != "" ? req : (n > 1 ? "R10" : tag_of(op)));
    endtask

    task automatic do_reset(logic with_req);
        rst_n = 1'b0;
        irq_take = with_req; call_en = with_req; jump_en = 0; ret_en = 0;
        retfie_en = with_req; retlw_en = 0; step = with_req; target = 13'h1555;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        compare("R2");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(1'b0);
        // R2: pop right after reset returns the cleared entry 0000h.
        drive(0,0,1,0,0,0,0, 13'h0123, "R5");
        drive(0,0,0,1,0,0,0, 13'h0000, "R2");
        // R4 wrap at the counter top, R1 fetch slice.
        drive(0,0,1,0,0,0,0, 13'h1FFE, "R1");
        drive(0,0,0,0,0,0,1, 13'h0000, "R4");
        drive(0,0,0,0,0,0,1, 13'h0000, "R4");
        drive(0,0,1,0,0,0,0, 13'h1ABC, "R1");
        // R11: nothing asserted.
        drive(0,0,0,0,0,0,0, 13'h0777, "R11");
        // R9: nine calls then nine returns wrap the circular stack.
        for (int k = 0; k < 9; k++) drive(0,1,0,0,0,0,0, 13'h0100 + 13'(k), "R9");
        for (int k = 0; k < 9; k++) drive(0,0,0,(k % 2 == 0),0,(k % 2 == 1),0, 13'h0, "R9");
        // R3 with concurrent requests, then R8 return from interrupt.
        drive(0,0,1,0,0,0,0, 13'h0ABC, "R5");
        drive(1,1,1,0,0,0,1, 13'h0333, "R3");
        drive(0,0,0,0,1,0,1, 13'h0000, "R8");
        drive(0,0,0,0,0,0,1, 13'h0000, "R8");
        // R10: call beats jump and return; return beats retfie (no pulse).
        drive(0,1,1,1,0,0,1, 13'h0444, "R10");
        drive(0,0,0,1,1,1,1, 13'h0000, "R10");
        // R2: reset wins over every request.
        do_reset(1'b1);
        // Random mix.
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 300 == 0) begin
                do_reset($urandom % 2 == 1);
            end else begin
                drive(($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
                      ($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
                      ($urandom % 2) == 0, 13'($urandom), "");
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule